// File: doc/BRIEF.md
# NAND Data-Phase Strobe Sequencer

This block carries out one byte transfer in the data phase of a NAND flash bus. A requester asks for a single read or write with a request/acknowledge handshake. The block then steps through three phases: an optional setup wait, a strobe pulse, and an optional hold wait. Reads and writes each have their own three counts. For a read, the block lowers the read strobe and captures the byte the device returns. For a write, it drives the byte onto the I/O bus and lowers the write strobe. A one-cycle completion pulse ends the transfer.

All six counts are held in one 32-bit timing register, which is written and read through a plain register port. The register is shared by every device on the bus. Each count is a number of bus clock cycles. A setup or hold count of zero removes that phase. A pulse count of zero is treated as one.

Top module: `nand_strobe_timer`

## Requirements
- R1: After reset the timing register reads 0x07770777. Both strobes (`reN`, `weN`) are high, `ioOe` is low and `done` is low.
- R2: The timing register holds these fields: write setup [2:0], write pulse [6:4], write hold [10:8], read setup [18:16], read pulse [22:20] and read hold [26:24]. Every other bit is storage only and reads back the value last written to it.
- R3: `reqAck` is high only in an idle cycle in which `reqValid` is high. No acknowledge is given from the accepting cycle until the cycle after `done`, even when `reqValid` stays high.
- R4: With a setup count S, the strobe first goes low S+1 cycles after the acknowledge cycle. With S=0 it goes low in the cycle right after the acknowledge.
- R5: The strobe of the requested kind stays low for P consecutive cycles, where P is the pulse count. A programmed pulse of 0 gives one cycle.
- R6: During a write, `ioOe` rises in the same cycle that `weN` falls. `ioOut` carries the request byte for every cycle in which `weN` is low.
- R7: After a write pulse, `ioOe` stays high for exactly the write hold count H of cycles past the rising edge of `weN`. With H=0 it falls together with `weN`.
- R8: `done` is high exactly 1+S+P+H cycles after the acknowledge cycle. No strobe is low during the setup or hold cycles.
- R9: Read data is sampled from `ioIn` in the last cycle of the `reN` pulse. The byte is held on `rdData` from `done` onward, until the next read.
- R10: `done` lasts one cycle. `reN` and `weN` are never low together. A read never lowers `weN` or raises `ioOe`, and a write never lowers `reN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every count is in cycles of this clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Writes `regWrData` into the timing register |
| regWrData | input | 32 | Value to write to the timing register |
| regRdData | output | 32 | Current contents of the timing register |
| reqValid | input | 1 | Requests a one-byte transfer |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWrData | input | 8 | Byte to write |
| reqAck | output | 1 | The request is accepted in this cycle |
| done | output | 1 | One-cycle pulse when the transfer is complete |
| rdData | output | 8 | Byte captured by the last read |
| reN | output | 1 | Read strobe, active low |
| weN | output | 1 | Write strobe, active low |
| ioOe | output | 1 | Output enable for the I/O bus driver |
| ioOut | output | 8 | Byte driven onto the I/O bus |
| ioIn | input | 8 | Byte returned by the device on the I/O bus |

## Verification
The bench runs transfers with setup and hold counts at zero, at small values and at the maximum, and with pulse counts of zero, one and seven. These cases separate a design that spends a cycle in an empty phase from one that skips it; a design with that fault shifts the strobe and `done` by one cycle. The simulated device drives its byte only while `reN` is low. A design that samples after the strobe rises therefore returns a filler pattern instead of the device byte. Writes are checked for the output enable lasting through the hold count and for the byte staying stable under the whole strobe. A design that dropped the driver at the strobe edge, or ignored the zero-pulse rule, would show a wrong enable length or strobe length.

// File: rtl/nand_tim_pkg.sv
package nand_tim_pkg;
  localparam int CNT_W = 3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD, PH_DONE
  } phase_t;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] pulse;
    logic [CNT_W-1:0] hold;
  } phaseCnt_t;

  typedef struct packed {
    logic loadWr;
    logic captureRd;
  } dpCtl_t;
endpackage

// File: rtl/nand_tim_dpath.sv
module nand_tim_dpath
  import nand_tim_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          REG_W     = 32,
  parameter logic [31:0] RESET_VAL = 32'h0777_0777
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] wrByte,
  input  logic [DATA_W-1:0] ioIn,
  output logic [DATA_W-1:0] ioOut,
  output logic [DATA_W-1:0] rdData,
  output phaseCnt_t         wrCnt,
  output phaseCnt_t         rdCnt
);
  localparam int WR_BASE = 0;
  localparam int RD_BASE = 16;
  localparam int STEP    = 4;

  logic [REG_W-1:0]  timingReg;
  logic [DATA_W-1:0] wrHold;
  logic [DATA_W-1:0] rdHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timingReg <= RESET_VAL[REG_W-1:0];
    else if (regWrEn) timingReg <= regWrData;
  end

  assign regRdData = timingReg;

  assign wrCnt.setup = timingReg[WR_BASE          +: CNT_W];
  assign wrCnt.pulse = timingReg[WR_BASE + STEP   +: CNT_W];
  assign wrCnt.hold  = timingReg[WR_BASE + 2*STEP +: CNT_W];
  assign rdCnt.setup = timingReg[RD_BASE          +: CNT_W];
  assign rdCnt.pulse = timingReg[RD_BASE + STEP   +: CNT_W];
  assign rdCnt.hold  = timingReg[RD_BASE + 2*STEP +: CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrHold <= '0;
      rdHold <= '0;
    end else begin
      if (ctl.loadWr)    wrHold <= wrByte;
      if (ctl.captureRd) rdHold <= ioIn;
    end
  end

  assign ioOut  = wrHold;
  assign rdData = rdHold;
endmodule

// File: rtl/nand_tim_ctrl.sv
module nand_tim_ctrl
  import nand_tim_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  phaseCnt_t wrCnt,
  input  phaseCnt_t rdCnt,
  output logic      reqAck,
  output logic      done,
  output logic      reN,
  output logic      weN,
  output logic      ioOe,
  output dpCtl_t    ctl
);
  phase_t           phase;
  logic             opWrite;
  logic [CNT_W-1:0] cnt;
  phaseCnt_t        selCnt;
  logic [CNT_W-1:0] effPulse;
  logic             lastCnt;

  assign selCnt   = (phase == PH_IDLE) ? (reqWrite ? wrCnt : rdCnt)
                                       : (opWrite  ? wrCnt : rdCnt);
  assign effPulse = (selCnt.pulse == '0) ? CNT_W'(1) : selCnt.pulse;
  assign lastCnt  = (cnt == CNT_W'(1));
  assign reqAck   = (phase == PH_IDLE) && reqValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      opWrite <= 1'b0;
      cnt     <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (reqValid) begin
          opWrite <= reqWrite;
          if (selCnt.setup != '0) begin
            phase <= PH_SETUP;
            cnt   <= selCnt.setup;
          end else begin
            phase <= PH_PULSE;
            cnt   <= effPulse;
          end
        end
        PH_SETUP: if (lastCnt) begin
          phase <= PH_PULSE;
          cnt   <= effPulse;
        end else cnt <= cnt - 1'b1;
        PH_PULSE: if (lastCnt) begin
          if (selCnt.hold != '0) begin
            phase <= PH_HOLD;
            cnt   <= selCnt.hold;
          end else phase <= PH_DONE;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (lastCnt) phase <= PH_DONE;
                 else cnt <= cnt - 1'b1;
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign reN           = !((phase == PH_PULSE) && !opWrite);
  assign weN           = !((phase == PH_PULSE) && opWrite);
  assign ioOe          = opWrite && ((phase == PH_PULSE) || (phase == PH_HOLD));
  assign done          = (phase == PH_DONE);
  assign ctl.loadWr    = reqAck && reqWrite;
  assign ctl.captureRd = (phase == PH_PULSE) && !opWrite && lastCnt;
endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
  import nand_tim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              reqAck,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              reN,
  output logic              weN,
  output logic              ioOe,
  output logic [DATA_W-1:0] ioOut,
  input  logic [DATA_W-1:0] ioIn
);
  dpCtl_t    ctl;
  phaseCnt_t wrCnt;
  phaseCnt_t rdCnt;

  nand_tim_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .wrCnt(wrCnt), .rdCnt(rdCnt), .reqAck(reqAck), .done(done),
    .reN(reN), .weN(weN), .ioOe(ioOe), .ctl(ctl)
  );

  nand_tim_dpath #(.DATA_W(DATA_W), .REG_W(REG_W)) u_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .ctl(ctl), .wrByte(reqWrData), .ioIn(ioIn),
    .ioOut(ioOut), .rdData(rdData), .wrCnt(wrCnt), .rdCnt(rdCnt)
  );
endmodule

// File: rtl/nand_strobe_timer_chk.sv
module nand_strobe_timer_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [REG_W-1:0] regRdData,
  input logic             reqValid,
  input logic             reqAck,
  input logic             done,
  input logic             reN,
  input logic             weN,
  input logic             ioOe
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(!reN && !weN));
  // R6
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rstN) !weN |-> ioOe);
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R3
  busy_noack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!weN || !reN || ioOe || done) |-> !reqAck);
  // R3
  ack_req_chk: assert property (@(posedge clk) disable iff (!rstN) reqAck |-> reqValid);
  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(weN) && (regRdData[10:8] != 3'd0)) |-> ioOe);
  // R10
  rd_no_oe_chk: assert property (@(posedge clk) disable iff (!rstN) !reN |-> !ioOe);
endmodule

bind nand_strobe_timer nand_strobe_timer_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .regRdData(regRdData), .reqValid(reqValid),
  .reqAck(reqAck), .done(done), .reN(reN), .weN(weN), .ioOe(ioOe)
);

// File: tb/nand_strobe_timer_tb.sv
module nand_strobe_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqWrData = '0;
  logic        reqAck, done, reN, weN, ioOe;
  logic [7:0]  rdData, ioOut, ioIn;
  logic [7:0]  devByte = '0;

  int checks = 0;
  int fails  = 0;
  logic [31:0] shadow = 32'h0777_0777;

  typedef struct {
    bit       isWr;
    bit [7:0] data;
    int       s, p, h;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  // device model: returns its byte only while the read strobe is low
  assign ioIn = reN ? 8'h3C : devByte;

  nand_strobe_timer u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWrData(reqWrData), .reqAck(reqAck), .done(done), .rdData(rdData),
    .reN(reN), .weN(weN), .ioOe(ioOe), .ioOut(ioOut), .ioIn(ioIn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [31:0] v);
    @(posedge clk); #1;
    regWrEn = 1'b1; regWrData = v;
    @(posedge clk); #1;
    regWrEn = 1'b0;
    shadow = v;
    @(negedge clk);
    check("R2 readback", regRdData, v);
  endtask

  task automatic doXfer(input bit isWr, input logic [7:0] data);
    exp_t e;
    int p;
    e.isWr = isWr;
    e.data = data;
    e.s = isWr ? int'(shadow[2:0])   : int'(shadow[18:16]);
    p   = isWr ? int'(shadow[6:4])   : int'(shadow[22:20]);
    e.p = (p == 0) ? 1 : p;
    e.h = isWr ? int'(shadow[10:8])  : int'(shadow[26:24]);
    expQ.push_back(e);
    @(posedge clk); #1;
    reqWrite  = isWr;
    reqWrData = data;
    if (!isWr) devByte = data;
    reqValid  = 1'b1;
    // request stays raised for the whole transfer (R3)
    forever begin
      @(negedge clk);
      if (done) break;
    end
    reqValid = 1'b0;
    if (!isWr) begin
      @(negedge clk);
      check("R9 rdData", rdData, data);
    end
  endtask

  // monitor
  bit tracking = 0;
  int t, firstStrobe, strobeLen, oeLen, ackDuring, wrongStrobe, dataBad;
  always @(negedge clk) begin
    if (rstN) begin
      if (!tracking) begin
        if (reqAck) begin
          tracking = 1; t = 0; firstStrobe = -1; strobeLen = 0; oeLen = 0;
          ackDuring = 0; wrongStrobe = 0; dataBad = 0;
        end
      end else begin
        exp_t e;
        t++;
        e = expQ[0];
        if (reqAck) ackDuring++;
        if (e.isWr) begin
          if (!weN) begin
            if (firstStrobe < 0) firstStrobe = t;
            strobeLen++;
            if (ioOut !== e.data || !ioOe) dataBad++;
          end
          if (!reN) wrongStrobe++;
        end else begin
          if (!reN) begin
            if (firstStrobe < 0) firstStrobe = t;
            strobeLen++;
          end
          if (!weN || ioOe) wrongStrobe++;
        end
        if (ioOe) oeLen++;
        if (done) begin
          check("R4 strobe start", firstStrobe, 1 + e.s);
          check("R5 strobe width", strobeLen, e.p);
          check("R8 done time", t, 1 + e.s + e.p + e.h);
          check("R3 no ack while busy", ackDuring, 0);
          check("R10 wrong strobe", wrongStrobe, 0);
          if (e.isWr) begin
            check("R6 write data", dataBad, 0);
            check("R7 oe length", oeLen, e.p + e.h);
          end
          void'(expQ.pop_front());
          tracking = 0;
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 reset reg", regRdData, 32'h0777_0777);
    check("R1 reN idle", reN, 1'b1);
    check("R1 weN idle", weN, 1'b1);
    check("R1 ioOe idle", ioOe, 1'b0);
    check("R1 done idle", done, 1'b0);

    doXfer(1, 8'hA5);
    doXfer(0, 8'h5A);

    regWrite(32'hF810_8818);      // zero setup/hold, pulse 1, reserved bits set
    doXfer(1, 8'h81);
    doXfer(0, 8'hC3);

    regWrite(32'h0003_0302);      // zero pulses treated as one
    doXfer(1, 8'h0F);
    doXfer(0, 8'hE7);

    regWrite(32'h0523_0142);
    doXfer(0, 8'h99);
    doXfer(1, 8'h66);
    doXfer(1, 8'h12);

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule